// File: doc/BRIEF.md
# Indexed Register and Memory Write Window

This bridge sits on the host write path of a device and offers indirect access through two host-visible locations: an index register and a four-byte data window. Software first places a target address in the index register, then writes byte, halfword or word data into the window. Bit 31 of the stored index chooses the destination. When it is set, the write goes to the frame memory port. When it is clear, the write is sent back into the local register decoder at the indexed address.

Memory writes are bounds-checked against a parameterised memory size, using arithmetic that cannot wrap. A write that falls outside is dropped without any indication. A register-bound index that points at or below the top byte of the window would loop back into the window, so it is refused and a one-cycle error pulse is raised. Host writes to any other address pass straight through to the register port.

Every outgoing write and every error pulse is registered. Each appears exactly one clock after the host write that caused it.

Top module: `idxwin_bridge`

## Requirements
- R1: A host write to the index address stores `host_wdata` with bits 1:0 forced to zero. The index register resets to zero. An index write produces no output write and no error.
- R2: A window write while index bit 31 is set produces `mem_we` one cycle later. `mem_waddr` equals index bits [MEM_AW-1:2], the word address. The byte offset inside the window does not affect the memory address.
- R3: Memory writes are little-endian, with data in the low lanes. Size code 0 (byte) gives `mem_be`=0001, code 1 (halfword) gives 0011, and code 2 (word) gives 1111. Lanes that are not enabled carry zero in `mem_wdata`.
- R4: A memory-bound window write is issued only if index[30:0] + access bytes <= MEM_BYTES, evaluated without wrap. Otherwise nothing happens and no error is flagged.
- R5: A window write while index bit 31 is clear and index > WIN_ADDR+3 produces `reg_we` one cycle later. It carries address index + window byte offset and the same size and data.
- R6: A window write while index bit 31 is clear and index <= WIN_ADDR+3 writes nothing. Instead, `win_err` is high for exactly one cycle, one cycle later.
- R7: A host write to an address that is neither the index nor the window produces `reg_we` one cycle later, with that address zero-extended and the same size and data.
- R8: Size code 3 is reserved. A host write using it has no effect anywhere, including on the index register.
- R9: At most one of `mem_we`, `reg_we` and `win_err` is high in any cycle. Each is high only in the cycle after a host write. Reset clears all three.
- R10: A register write forwarded from the window never targets an address inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HA_W | Host byte address |
| host_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| host_wdata | input | 32 | Host write data, low lanes used for narrow sizes |
| mem_we | output | 1 | Frame memory write strobe |
| mem_waddr | output | MEM_AW-2 | Frame memory word address |
| mem_be | output | 4 | Frame memory byte enables |
| mem_wdata | output | 32 | Frame memory write data |
| reg_we | output | 1 | Register decoder write strobe |
| reg_waddr | output | 32 | Register decoder byte address |
| reg_size | output | 2 | Register write size code |
| reg_wdata | output | 32 | Register write data |
| win_err | output | 1 | One-cycle pulse for a window write with an index that is too low |

## Verification
The bound checker watches several properties on every clock:
- the three outputs are mutually exclusive;
- every output pulse and memory write traces back to a host write of the right kind in the previous cycle;
- the byte-enable patterns are legal;
- the forwarded size is preserved;
- reserved sizes are inert;
- no forwarded window write lands back inside the window.

Other behaviours depend on values stored from earlier writes, so only the bench scenarios can show them:
- the exact forwarded address;
- the low-bit clearing of the index;
- the memory bounds edge at MEM_BYTES;
- the wrap case near the top of the index range;
- the reset value of the index.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      RT_NONE = 2'd0,
      RT_MEM  = 2'd1,
      RT_REG  = 2'd2,
      RT_ERR  = 2'd3
   } route_e;

   // number of bytes moved for a size code; zero for the reserved code
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_HALF: size_bytes = 3'd2;
         SZ_WORD: size_bytes = 3'd4;
         default: size_bytes = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/idxwin_route.sv
module idxwin_route
   import idxwin_pkg::*;
#(
   parameter int unsigned HA_W       = 12,
   parameter int unsigned INDEX_ADDR = 0,
   parameter int unsigned WIN_ADDR   = 4,
   parameter int unsigned MEM_BYTES  = 65536
) (
   input  logic            host_we,
   input  logic [HA_W-1:0] host_addr,
   input  logic [1:0]      host_size,
   input  logic [31:0]     index_q,
   output logic            load_index,
   output route_e          route,
   output logic [31:0]     fwd_addr
);
   localparam logic [HA_W-1:0] IDX_L   = HA_W'(INDEX_ADDR);
   localparam logic [HA_W-1:0] WIN_L   = HA_W'(WIN_ADDR);
   localparam logic [31:0]     WIN_TOP = 32'(WIN_ADDR) + 32'd3;
   localparam logic [32:0]     MEM_LIM = 33'(MEM_BYTES);

   logic       size_ok;
   logic       hit_index;
   logic       hit_window;
   logic       to_memory;
   logic       mem_fits;
   logic       above_win;
   logic [2:0] nbytes;
   logic [32:0] span_end;

   always_comb begin
      nbytes     = size_bytes(host_size);
      size_ok    = (host_size != SZ_RSVD);
      hit_index  = (host_addr == IDX_L);
      hit_window = (host_addr[HA_W-1:2] == WIN_L[HA_W-1:2]);
      to_memory  = index_q[31];
      // widened sum: cannot wrap whatever the index holds
      span_end   = {2'b00, index_q[30:0]} + {30'd0, nbytes};
      mem_fits   = (span_end <= MEM_LIM);
      above_win  = (index_q > WIN_TOP);

      load_index = host_we && size_ok && hit_index;
      route      = RT_NONE;
      fwd_addr   = 32'(host_addr);

      if (host_we && size_ok && !hit_index) begin
         if (hit_window) begin
            fwd_addr = index_q + {30'd0, host_addr[1:0]};
            if (to_memory) begin
               if (mem_fits) route = RT_MEM;
            end else if (above_win) begin
               route = RT_REG;
            end else begin
               route = RT_ERR;
            end
         end else begin
            route = RT_REG;
         end
      end
   end

endmodule

// File: rtl/idxwin_lanes.sv
module idxwin_lanes
   import idxwin_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic [1:0]         size,
   input  logic [8*LANES-1:0] data_in,
   output logic [LANES-1:0]   be,
   output logic [8*LANES-1:0] data_out
);
   logic [2:0] nbytes;
   assign nbytes = size_bytes(size);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be[i]            = (32'(i) < 32'(nbytes));
      assign data_out[8*i +: 8] = be[i] ? data_in[8*i +: 8] : 8'h00;
   end

endmodule

// File: rtl/idxwin_bridge.sv
module idxwin_bridge
   import idxwin_pkg::*;
#(
   parameter int unsigned HA_W       = 12,
   parameter int unsigned INDEX_ADDR = 0,
   parameter int unsigned WIN_ADDR   = 4,
   parameter int unsigned MEM_BYTES  = 65536,
   localparam int unsigned MEM_AW    = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [HA_W-1:0]   host_addr,
   input  logic [1:0]        host_size,
   input  logic [31:0]       host_wdata,
   output logic              mem_we,
   output logic [MEM_AW-3:0] mem_waddr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   output logic              reg_we,
   output logic [31:0]       reg_waddr,
   output logic [1:0]        reg_size,
   output logic [31:0]       reg_wdata,
   output logic              win_err
);
   if (HA_W < 3 || HA_W > 31) begin : g_bad_haw
      $error("HA_W out of range");
   end
   if (WIN_ADDR % 4 != 0) begin : g_bad_win
      $error("WIN_ADDR must be word aligned");
   end
   if (INDEX_ADDR >= WIN_ADDR && INDEX_ADDR <= WIN_ADDR + 3) begin : g_bad_idx
      $error("INDEX_ADDR overlaps window");
   end
   if (MEM_BYTES < 8 || MEM_BYTES % 4 != 0 || MEM_AW > 31) begin : g_bad_mem
      $error("MEM_BYTES must be a multiple of 4, at least 8, below 2**31");
   end

   logic [31:0] index_q;
   logic        load_index;
   route_e      route;
   logic [31:0] fwd_addr;
   logic [3:0]  lane_be;
   logic [31:0] lane_data;

   idxwin_route #(
      .HA_W      (HA_W),
      .INDEX_ADDR(INDEX_ADDR),
      .WIN_ADDR  (WIN_ADDR),
      .MEM_BYTES (MEM_BYTES)
   ) u_route (
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_size (host_size),
      .index_q   (index_q),
      .load_index(load_index),
      .route     (route),
      .fwd_addr  (fwd_addr)
   );

   idxwin_lanes #(.LANES(4)) u_lanes (
      .size    (host_size),
      .data_in (host_wdata),
      .be      (lane_be),
      .data_out(lane_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q   <= '0;
         mem_we    <= 1'b0;
         mem_waddr <= '0;
         mem_be    <= '0;
         mem_wdata <= '0;
         reg_we    <= 1'b0;
         reg_waddr <= '0;
         reg_size  <= '0;
         reg_wdata <= '0;
         win_err   <= 1'b0;
      end else begin
         if (load_index) index_q <= {host_wdata[31:2], 2'b00};
         mem_we  <= (route == RT_MEM);
         reg_we  <= (route == RT_REG);
         win_err <= (route == RT_ERR);
         if (route == RT_MEM) begin
            mem_waddr <= index_q[MEM_AW-1:2];
            mem_be    <= lane_be;
            mem_wdata <= lane_data;
         end
         if (route == RT_REG) begin
            reg_waddr <= fwd_addr;
            reg_size  <= host_size;
            reg_wdata <= host_wdata;
         end
      end
   end

endmodule

// File: rtl/idxwin_bridge_chk.sv
module idxwin_bridge_chk #(
   parameter int unsigned HA_W     = 12,
   parameter int unsigned WIN_ADDR = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            host_we,
   input logic [HA_W-1:0] host_addr,
   input logic [1:0]      host_size,
   input logic            mem_we,
   input logic [3:0]      mem_be,
   input logic            reg_we,
   input logic [31:0]     reg_waddr,
   input logic [1:0]      reg_size,
   input logic            win_err
);
   localparam logic [HA_W-1:0] WIN_L   = HA_W'(WIN_ADDR);
   localparam logic [31:0]     WIN_TOP = 32'(WIN_ADDR) + 32'd3;

   logic in_win;
   assign in_win = (host_addr[HA_W-1:2] == WIN_L[HA_W-1:2]);

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, reg_we, win_err}));

   a_r9_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !(mem_we || reg_we || win_err));

   a_r2_mem_from_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(host_we && in_win));

   a_r6_err_from_window: assert property (@(posedge clk) disable iff (!rst_n)
      win_err |-> $past(host_we && in_win));

   a_r9_reg_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(host_we));

   a_r3_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_be == 4'b0001 || mem_be == 4'b0011 || mem_be == 4'b1111));

   a_r5_size_kept: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (reg_size == $past(host_size)));

   a_r8_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_size == 2'd3) |=> !(mem_we || reg_we || win_err));

   a_r10_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && $past(host_we && in_win)) |-> (reg_waddr > WIN_TOP));

endmodule

bind idxwin_bridge idxwin_bridge_chk #(
   .HA_W    (HA_W),
   .WIN_ADDR(WIN_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_we  (host_we),
   .host_addr(host_addr),
   .host_size(host_size),
   .mem_we   (mem_we),
   .mem_be   (mem_be),
   .reg_we   (reg_we),
   .reg_waddr(reg_waddr),
   .reg_size (reg_size),
   .win_err  (win_err)
);

// File: tb/idxwin_bridge_tb_top.sv
module idxwin_bridge_tb_top;
   localparam int unsigned HA_W   = 12;
   localparam int unsigned MEMSZ  = 256;
   localparam int unsigned MEM_AW = $clog2(MEMSZ);
   localparam logic [HA_W-1:0] A_IDX = 12'h000;
   localparam logic [HA_W-1:0] A_WIN = 12'h004;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_we = 1'b0;
   logic [HA_W-1:0] host_addr = '0;
   logic [1:0]  host_size = '0;
   logic [31:0] host_wdata = '0;
   logic mem_we, reg_we, win_err;
   logic [MEM_AW-3:0] mem_waddr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata, reg_waddr, reg_wdata;
   logic [1:0]  reg_size;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   idxwin_bridge #(
      .HA_W(HA_W), .INDEX_ADDR(0), .WIN_ADDR(4), .MEM_BYTES(MEMSZ)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_size(host_size), .host_wdata(host_wdata),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_size(reg_size), .reg_wdata(reg_wdata), .win_err(win_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one host write; on return the registered result is on the outputs
   task automatic hwrite(input logic [HA_W-1:0] a, input logic [1:0] sz, input logic [31:0] d);
      host_addr = a; host_size = sz; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
   endtask

   function automatic logic [2:0] strobes();
      return {mem_we, reg_we, win_err};
   endfunction

   task automatic t_reset();
      check("R9 reset strobes", 32'(strobes()), 32'd0);
      // index resets to zero, so a register-bound window write errors (R1/R6)
      hwrite(A_WIN, 2'd2, 32'h1234_5678);
      check("R1 index reset zero -> err", 32'(strobes()), 32'b001);
   endtask

   task automatic t_index_low_bits();
      hwrite(A_IDX, 2'd2, 32'h0000_0107);
      check("R1 index write quiet", 32'(strobes()), 32'd0);
      hwrite(A_WIN + 12'd2, 2'd0, 32'h0000_00AB);
      check("R5 reg_we", 32'(reg_we), 32'd1);
      check("R1 low bits cleared, R5 addr", reg_waddr, 32'h0000_0106);
      check("R5 size", 32'(reg_size), 32'd0);
      check("R5 data", reg_wdata, 32'h0000_00AB);
      idle_cycle();
      check("R9 reg_we one cycle", 32'(strobes()), 32'd0);
   endtask

   task automatic t_mem_word();
      hwrite(A_IDX, 2'd2, 32'h8000_0010);
      hwrite(A_WIN + 12'd1, 2'd2, 32'hA1B2_C3D4);
      check("R2 mem_we only", 32'(strobes()), 32'b100);
      check("R2 word addr", 32'(mem_waddr), 32'd4);
      check("R3 be word", 32'(mem_be), 32'hF);
      check("R3 data word", mem_wdata, 32'hA1B2_C3D4);
   endtask

   task automatic t_mem_narrow();
      hwrite(A_IDX, 2'd2, 32'h8000_0020);
      hwrite(A_WIN + 12'd3, 2'd0, 32'h1122_33EE);
      check("R2 offset ignored addr", 32'(mem_waddr), 32'd8);
      check("R3 be byte", 32'(mem_be), 32'h1);
      check("R3 data byte", mem_wdata, 32'h0000_00EE);
      hwrite(A_WIN, 2'd1, 32'h5566_7788);
      check("R3 be half", 32'(mem_be), 32'h3);
      check("R3 data half", mem_wdata, 32'h0000_7788);
   endtask

   task automatic t_bounds();
      hwrite(A_IDX, 2'd2, 32'h8000_00FC);
      hwrite(A_WIN, 2'd2, 32'hCAFE_F00D);
      check("R4 last word fits", 32'(strobes()), 32'b100);
      check("R4 last word addr", 32'(mem_waddr), 32'd63);
      hwrite(A_IDX, 2'd2, 32'h8000_0100);
      hwrite(A_WIN, 2'd0, 32'h0000_0001);
      check("R4 past end dropped silently", 32'(strobes()), 32'd0);
      hwrite(A_IDX, 2'd2, 32'hFFFF_FFFC);
      hwrite(A_WIN, 2'd2, 32'h0000_0002);
      check("R4 no wrap near top", 32'(strobes()), 32'd0);
   endtask

   task automatic t_err_edges();
      hwrite(A_IDX, 2'd2, 32'h0000_0004);
      hwrite(A_WIN, 2'd2, 32'h0);
      check("R6 index at window err", 32'(strobes()), 32'b001);
      idle_cycle();
      check("R6 err one cycle", 32'(win_err), 32'd0);
      hwrite(A_IDX, 2'd2, 32'h0000_0008);
      hwrite(A_WIN + 12'd3, 2'd1, 32'h0000_BEEF);
      check("R5 boundary forwards", 32'(strobes()), 32'b010);
      check("R10 addr above window", reg_waddr, 32'h0000_000B);
      check("R5 half size kept", 32'(reg_size), 32'd1);
   endtask

   task automatic t_direct();
      hwrite(12'h200, 2'd2, 32'hDEAD_BEEF);
      check("R7 direct reg_we", 32'(strobes()), 32'b010);
      check("R7 direct addr", reg_waddr, 32'h0000_0200);
      check("R7 direct data", reg_wdata, 32'hDEAD_BEEF);
   endtask

   task automatic t_reserved();
      hwrite(A_IDX, 2'd2, 32'h8000_0040);
      hwrite(A_WIN, 2'd3, 32'h1);
      check("R8 window rsvd inert", 32'(strobes()), 32'd0);
      hwrite(A_IDX, 2'd3, 32'h0000_0300);
      check("R8 index rsvd quiet", 32'(strobes()), 32'd0);
      hwrite(A_WIN, 2'd2, 32'h0);
      check("R8 index kept: mem path", 32'(strobes()), 32'b100);
      check("R8 index kept: addr", 32'(mem_waddr), 32'd16);
      hwrite(12'h300, 2'd3, 32'h1);
      check("R8 direct rsvd inert", 32'(strobes()), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_index_low_bits();
      t_mem_word();
      t_mem_narrow();
      t_bounds();
      t_err_edges();
      t_direct();
      t_reserved();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule